// File: doc/BRIEF.md
# CAN Base-Frame Transmitter with Bitwise Arbitration

This block turns one request into a classic base-format CAN frame and drives it one bit at a time onto a single open-drain line. A logic 0 is dominant and a logic 1 is recessive, and the line behaves as a wired-AND of all nodes. A request carries an 11-bit identifier, a remote-request flag, a 4-bit length code and eight data bytes. The block forms the frame fields, computes the 15-bit CRC, inserts stuff bits and appends the delimiters, the acknowledge slot and end-of-frame. An external strobe paces the bits: each `bit_tick` ends the bit now on the line and starts the next one.

The block reads back every bit it drives. While it sends the identifier and the remote-request bit, a recessive bit that comes back dominant means another node holds a lower identifier. The block then stops driving at once and reports the loss, so the other node's frame goes on unharmed. After the CRC, the block samples the acknowledge slot and reports either success or a missing acknowledge.

Requests use a valid/ready handshake. A request is taken on the clock where `req_valid` and `req_ready` are both high. `req_ready` stays low from that clock until the frame ends, so a held request simply waits. The request fields only need to be valid on the accepting clock.

Top module: `can_frame_tx`

## Requirements
- R1: Out of reset, `tx_bit` is 1, `req_ready` is 1 and `done` is 0. A request is taken only on a clock with `req_valid && req_ready`. `req_ready` is then 0 until the clock on which `done` pulses. While the block is busy, `req_valid` and the request fields have no effect on the frame, and `tx_bit` is 1 whenever `req_ready` is 1.
- R2: `tx_bit` changes only on the clock edge where `bit_tick` is high, and at most one bit is sent per tick. The first tick after a request is taken places start-of-frame (0) on the line.
- R3: Bit order on the line, ignoring stuff bits: start-of-frame 0, identifier MSB first, the remote-request bit, two reserved 0 bits, the length code MSB first, the data bytes, CRC MSB first, a 1 delimiter, the acknowledge slot sent as 1, a 1 delimiter and seven 1 end-of-frame bits. Data byte k is `req_data[8k+7:8k]`, byte 0 goes first and each byte goes MSB first.
- R4: A data frame carries min(length code, 8) bytes. The length code is sent on the line exactly as given, including values 9 to 15.
- R5: With `req_rtr` = 1 the block sends a remote frame. The remote-request bit is 1, no data bytes follow, and the length code is still sent as given.
- R6: The CRC is 15 bits, uses generator 0x4599 and starts from zero. It covers the unstuffed bits from start-of-frame through the last data bit.
- R7: After five equal bits in a row from start-of-frame through the last CRC bit, one bit of the opposite level is inserted. Inserted bits count toward the next run. The rule can insert a bit after the last CRC bit. It never applies from the CRC delimiter onward.
- R8: Arbitration covers the identifier bits, the remote-request bit and the stuff bits between them. If the block reads back 0 while sending 1 in that range, it releases the line (`tx_bit` = 1) at that tick and keeps it released. `done` then pulses with `done_code` = 2'b01.
- R9: A node that reads back its own level throughout arbitration continues the whole frame. A lower identifier, or a data frame against a remote frame with the same identifier, wins.
- R10: The acknowledge slot is judged at the tick that ends it. A 0 gives `done_code` = 2'b00. A 1 gives 2'b10, and the full end-of-frame is still sent.
- R11: `done` is a one-clock pulse with `done_code` valid in the same clock. It occurs on the clock of the tick that ends the last end-of-frame bit, or on the clock of the tick that detects lost arbitration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-clock strobe that ends the current bit |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request accepted when valid is high too |
| req_id | input | 11 | Identifier, lower value wins |
| req_rtr | input | 1 | 1 = remote frame |
| req_dlc | input | 4 | Length code |
| req_data | input | 64 | Data bytes, byte k at bits 8k+7:8k |
| tx_bit | output | 1 | Level driven on the line, 0 dominant |
| rx_bit | input | 1 | Level read back from the line |
| done | output | 1 | Frame finished pulse |
| done_code | output | 2 | 00 sent and acknowledged, 01 arbitration lost, 10 no acknowledge |

## Verification
The in-line assertions check on every clock that the line level moves only on a tick and is recessive while idle. They also check that a due stuff bit really opposes the run, that the CRC register holds outside the body bits, that the finish strobe lasts one clock, and that the line is released whenever a loss is reported. Only the bench scenarios can show the exact bit sequence: the field order, the CRC value, stuff bits at field edges, the byte clamp for long length codes, and the remote-frame layout. The scenarios also show which competitor wins arbitration, whether the winning frame survives, and how the acknowledge outcome is reported.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_BODY, PH_CRC, PH_CDEL, PH_ACK, PH_ADEL, PH_EOF, PH_END
  } tx_phase_t;

  typedef enum logic [1:0] {
    RES_OK    = 2'b00,
    RES_LOST  = 2'b01,
    RES_NOACK = 2'b10
  } tx_result_t;
endpackage

// File: rtl/can_crc_unit.sv
module can_crc_unit #(
  parameter int W = 15,
  parameter logic [W-1:0] POLY = 15'h4599
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_nxt;

  always_comb begin
    crc_nxt = {crc[W-2:0], 1'b0};
    if (din ^ crc[W-1]) crc_nxt = crc_nxt ^ POLY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= crc_nxt;
  end

  // R6
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(crc));
endmodule

// File: rtl/can_stuff_track.sv
module can_stuff_track #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic emit,
  input  logic bit_in,
  input  logic stuffable,
  output logic stuff_due,
  output logic last_bit
);
  localparam int RW = $clog2(RUN + 1);
  localparam logic [RW-1:0] RUN_C = RW'(RUN);

  logic [RW-1:0] run_q;
  logic          zone_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0; zone_q <= 1'b0; last_bit <= 1'b1;
    end else if (clr) begin
      run_q <= '0; zone_q <= 1'b0; last_bit <= 1'b1;
    end else if (emit) begin
      last_bit <= bit_in;
      zone_q   <= stuffable;
      if (run_q != '0 && bit_in == last_bit)
        run_q <= (run_q == RUN_C) ? RUN_C : run_q + 1'b1;
      else
        run_q <= RW'(1);
    end
  end

  assign stuff_due = zone_q && (run_q == RUN_C);

  // R7
  stuff_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff_due && emit) |-> (bit_in != last_bit));
endmodule

// File: rtl/can_frame_tx.sv
module can_frame_tx
  import can_tx_pkg::*;
#(
  parameter int ID_W      = 11,
  parameter int DLC_W     = 4,
  parameter int MAX_BYTES = 8,
  parameter int CRC_W     = 15,
  parameter logic [CRC_W-1:0] CRC_POLY = 15'h4599,
  parameter int STUFF_RUN = 5,
  parameter int EOF_LEN   = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_tick,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ID_W-1:0]        req_id,
  input  logic                   req_rtr,
  input  logic [DLC_W-1:0]       req_dlc,
  input  logic [8*MAX_BYTES-1:0] req_data,
  output logic                   tx_bit,
  input  logic                   rx_bit,
  output logic                   done,
  output logic [1:0]             done_code
);
  localparam int DATA_W   = 8 * MAX_BYTES;
  localparam int HDR_BITS = 1 + ID_W + 1 + 2 + DLC_W;
  localparam int BODY_MAX = HDR_BITS + DATA_W;
  localparam int CNT_W    = $clog2(BODY_MAX + 1);
  localparam int CRC_CW   = $clog2(CRC_W + 1);
  localparam int EOF_CW   = $clog2(EOF_LEN + 1);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO_C  = CNT_W'(2);
  localparam logic [CNT_W-1:0] ARB_HI = CNT_W'(ID_W + 1);

  tx_phase_t           phase, ph_nxt;
  logic [BODY_MAX-1:0] body_sr;
  logic [CNT_W-1:0]    body_left, ucnt, n_bytes, body_len;
  logic [CRC_CW-1:0]   crc_left;
  logic [EOF_CW-1:0]   eof_left;
  logic [CRC_W-1:0]    crc_val;
  logic [DATA_W-1:0]   data_seq;
  logic                tx_q, cur_arb, cur_ack, ack_seen;
  logic                load, lost, finish;
  logic                emit, e_bit, e_arb, e_ack, e_zone, crc_en;
  logic                body_step, crc_step, eof_step;
  logic                stuff_due, last_bit;

  // byte 0 leaves first: reorder into a shift image
  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_byte_order
    assign data_seq[8*(MAX_BYTES-1-k) +: 8] = req_data[8*k +: 8];
  end

  always_comb begin
    if (req_rtr)                           n_bytes = '0;
    else if (32'(req_dlc) > MAX_BYTES)     n_bytes = CNT_W'(MAX_BYTES);
    else                                   n_bytes = CNT_W'(req_dlc);
    body_len = CNT_W'(HDR_BITS) + {n_bytes[CNT_W-4:0], 3'b000};
  end

  assign req_ready = (phase == PH_IDLE);
  assign load      = req_valid && req_ready;
  assign tx_bit    = tx_q;
  assign lost      = bit_tick && cur_arb && tx_q && !rx_bit;

  can_crc_unit #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(load), .en(crc_en), .din(e_bit), .crc(crc_val)
  );

  can_stuff_track #(.RUN(STUFF_RUN)) u_stuff (
    .clk(clk), .rst_n(rst_n), .clr(load), .emit(emit), .bit_in(e_bit),
    .stuffable(e_zone), .stuff_due(stuff_due), .last_bit(last_bit)
  );

  // choose the next bit to put on the line
  always_comb begin
    emit = 1'b0; e_bit = 1'b1; e_arb = 1'b0; e_ack = 1'b0; e_zone = 1'b0;
    crc_en = 1'b0; body_step = 1'b0; crc_step = 1'b0; eof_step = 1'b0;
    finish = 1'b0; ph_nxt = phase;
    if (bit_tick && !lost && phase != PH_IDLE) begin
      if (stuff_due && (phase == PH_BODY || phase == PH_CRC || phase == PH_CDEL)) begin
        emit = 1'b1; e_bit = ~last_bit; e_zone = 1'b1;
        e_arb = (ucnt >= TWO_C) && (ucnt <= ARB_HI);
      end else begin
        case (phase)
          PH_BODY: begin
            emit = 1'b1; e_bit = body_sr[BODY_MAX-1]; e_zone = 1'b1;
            crc_en = 1'b1; body_step = 1'b1;
            e_arb = (ucnt >= ONE_C) && (ucnt <= ARB_HI);
            if (body_left == ONE_C) ph_nxt = PH_CRC;
          end
          PH_CRC: begin
            emit = 1'b1; e_bit = crc_val[crc_left - 1'b1]; e_zone = 1'b1;
            crc_step = 1'b1;
            if (crc_left == CRC_CW'(1)) ph_nxt = PH_CDEL;
          end
          PH_CDEL: begin emit = 1'b1; ph_nxt = PH_ACK; end
          PH_ACK:  begin emit = 1'b1; e_ack = 1'b1; ph_nxt = PH_ADEL; end
          PH_ADEL: begin emit = 1'b1; ph_nxt = PH_EOF; end
          PH_EOF: begin
            emit = 1'b1; eof_step = 1'b1;
            if (eof_left == EOF_CW'(1)) ph_nxt = PH_END;
          end
          PH_END:  begin finish = 1'b1; ph_nxt = PH_IDLE; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; body_sr <= '0; body_left <= '0; ucnt <= '0;
      crc_left <= '0; eof_left <= '0; tx_q <= 1'b1; cur_arb <= 1'b0;
      cur_ack <= 1'b0; ack_seen <= 1'b0; done <= 1'b0; done_code <= RES_OK;
    end else begin
      done <= 1'b0;
      if (load) begin
        phase     <= PH_BODY;
        body_sr   <= {1'b0, req_id, req_rtr, 2'b00, req_dlc, data_seq};
        body_left <= body_len;
        ucnt      <= '0;
        crc_left  <= CRC_CW'(CRC_W);
        eof_left  <= EOF_CW'(EOF_LEN);
        cur_arb   <= 1'b0;
        cur_ack   <= 1'b0;
        ack_seen  <= 1'b0;
      end else if (lost) begin
        phase     <= PH_IDLE;
        tx_q      <= 1'b1;
        cur_arb   <= 1'b0;
        done      <= 1'b1;
        done_code <= RES_LOST;
      end else if (bit_tick && phase != PH_IDLE) begin
        if (cur_ack) ack_seen <= ~rx_bit;
        if (emit) begin
          tx_q    <= e_bit;
          cur_arb <= e_arb;
          cur_ack <= e_ack;
        end
        if (body_step) begin
          body_sr   <= {body_sr[BODY_MAX-2:0], 1'b0};
          body_left <= body_left - 1'b1;
          ucnt      <= ucnt + 1'b1;
        end
        if (crc_step) crc_left <= crc_left - 1'b1;
        if (eof_step) eof_left <= eof_left - 1'b1;
        phase <= ph_nxt;
        if (finish) begin
          done      <= 1'b1;
          done_code <= ack_seen ? RES_OK : RES_NOACK;
          tx_q      <= 1'b1;
          cur_arb   <= 1'b0;
        end
      end
    end
  end

  // R2
  tick_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(tx_bit));
  // R1
  idle_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> tx_bit);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_code == RES_LOST) |-> tx_bit);
endmodule

// File: tb/sim_can_frame_tx.sv
module sim_can_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_rtr = 1'b0;
  logic [10:0] req_id = '0;
  logic [3:0]  req_dlc = '0;
  logic [63:0] req_data = '0;
  logic        req_ready, tx_bit, done, rx_bit;
  logic [1:0]  done_code;
  logic        oth_tx = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  assign rx_bit = tx_bit & oth_tx;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_rtr(req_rtr), .req_dlc(req_dlc), .req_data(req_data),
    .tx_bit(tx_bit), .rx_bit(rx_bit), .done(done), .done_code(done_code)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // reference frame builder: result in bq, arbitration end and ack slot index
  bit bq[$];
  int b_arb_last;
  int b_ack;

  task automatic build(input logic [10:0] id, input bit rtr,
                       input logic [3:0] dlc, input logic [63:0] data);
    bit u[$];
    logic [14:0] crc;
    int nb;
    int run;
    bit last;
    u.push_back(1'b0);                                   // R3 start-of-frame
    for (int i = 10; i >= 0; i--) u.push_back(id[i]);
    u.push_back(rtr);                                    // R5
    u.push_back(1'b0); u.push_back(1'b0);
    for (int i = 3; i >= 0; i--) u.push_back(dlc[i]);
    nb = rtr ? 0 : ((dlc > 8) ? 8 : int'(dlc));          // R4
    for (int k = 0; k < nb; k++)
      for (int b = 7; b >= 0; b--) u.push_back(data[8*k+b]);
    crc = '0;                                            // R6
    foreach (u[j]) crc = {crc[13:0], 1'b0} ^ ((u[j] ^ crc[14]) ? 15'h4599 : 15'h0);
    for (int i = 14; i >= 0; i--) u.push_back(crc[i]);
    bq.delete();
    run = 0; last = 1'b1;
    foreach (u[j]) begin                                 // R7
      bq.push_back(u[j]);
      if (j == 12) b_arb_last = bq.size() - 1;
      if (run > 0 && u[j] == last) run++; else run = 1;
      last = u[j];
      if (run == 5) begin bq.push_back(!last); last = !last; run = 1; end
    end
    bq.push_back(1'b1);
    b_ack = bq.size();
    bq.push_back(1'b1); bq.push_back(1'b1);
    for (int i = 0; i < 7; i++) bq.push_back(1'b1);
  endtask

  task automatic run_frame(input string tag,
                           input logic [10:0] id, input bit rtr,
                           input logic [3:0] dlc, input logic [63:0] data,
                           input bit has_oth, input logic [10:0] oid,
                           input bit ortr, input bit give_ack, input bit noise);
    bit mine[$]; bit oq[$];
    int m_arb, m_ack, o_arb;
    int idx, oidx;
    bit exp_tx, bus, finished, fin_now, o_act, ack_ok, nxt_oth;
    int got;
    string ftag;
    if (has_oth) begin
      build(oid, ortr, dlc, data);
      oq = bq; o_arb = b_arb_last;
    end
    build(id, rtr, dlc, data);
    mine = bq; m_arb = b_arb_last; m_ack = b_ack;

    @(negedge clk);
    req_id = id; req_rtr = rtr; req_dlc = dlc; req_data = data; req_valid = 1'b1;
    @(negedge clk);
    req_valid = noise;
    if (noise) begin req_id = ~id; req_rtr = ~rtr; req_dlc = 4'd1; req_data = ~data; end
    chk(req_ready == 1'b0, "R1", "ready after accept", int'(req_ready), 0);

    exp_tx = 1'b1; idx = -1; oidx = -1; o_act = has_oth;
    finished = 1'b0; ack_ok = 1'b0; got = 0;
    while (!finished || o_act) begin
      bit_tick = 1'b1;
      bus = exp_tx & oth_tx;
      fin_now = 1'b0;
      if (!finished) begin
        if (idx >= 1 && idx <= m_arb && exp_tx && !bus) begin
          finished = 1'b1; fin_now = 1'b1; got = 1; exp_tx = 1'b1;
        end else begin
          if (idx == m_ack) ack_ok = !bus;
          idx++;
          if (idx < mine.size()) exp_tx = mine[idx];
          else begin finished = 1'b1; fin_now = 1'b1; got = ack_ok ? 0 : 2; exp_tx = 1'b1; end
        end
      end
      if (o_act) begin
        if (oidx >= 1 && oidx <= o_arb && oth_tx && !bus) o_act = 1'b0;
        else begin oidx++; if (oidx >= oq.size()) o_act = 1'b0; end
      end
      if (o_act) nxt_oth = oq[oidx];
      else nxt_oth = !(give_ack && !finished && idx == m_ack);

      @(negedge clk);
      bit_tick = 1'b0;
      oth_tx = nxt_oth;
      chk(tx_bit === exp_tx, tag, "line bit", int'(tx_bit), int'(exp_tx));
      chk(done === fin_now, "R11", "done strobe", int'(done), int'(fin_now));
      chk(req_ready === finished, "R1", "ready level", int'(req_ready), int'(finished));
      if (fin_now) begin
        ftag = (got == 1) ? "R8" : "R10";
        chk(done_code == 2'(got), ftag, "result code", int'(done_code), got);
        if (noise) req_valid = 1'b0;
      end
      for (int c = 0; c < TICK_DIV - 1; c++) begin
        @(negedge clk);
        chk(tx_bit === exp_tx, "R2", "bit held between ticks", int'(tx_bit), int'(exp_tx));
        chk(done === 1'b0, "R11", "done outside tick", int'(done), 0);
      end
    end
    oth_tx = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(tx_bit === 1'b1 && req_ready === 1'b1, "R1", "idle after frame",
          int'({tx_bit, req_ready}), 3);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_bit === 1'b1, "R1", "reset line level", int'(tx_bit), 1);
    chk(req_ready === 1'b1, "R1", "reset ready", int'(req_ready), 1);
    chk(done === 1'b0, "R1", "reset done", int'(done), 0);
    // R3 R6 plain data frame, acknowledged
    run_frame("R3", 11'h123, 1'b0, 4'd2, 64'h0000_0000_0000_5AA5, 1'b0, '0, 1'b0, 1'b1, 1'b0);
    // R6 R7 long zero runs
    run_frame("R7", 11'h000, 1'b0, 4'd8, 64'h0, 1'b0, '0, 1'b0, 1'b1, 1'b0);
    // R7 long one runs
    run_frame("R7", 11'h7FF, 1'b0, 4'd8, {64{1'b1}}, 1'b0, '0, 1'b0, 1'b1, 1'b0);
    // R5 remote frame: data ignored
    run_frame("R5", 11'h2A5, 1'b1, 4'd4, 64'h1122_3344_5566_7788, 1'b0, '0, 1'b0, 1'b1, 1'b0);
    // R4 length code above eight
    run_frame("R4", 11'h0F0, 1'b0, 4'd12, 64'hDEAD_BEEF_0123_4567, 1'b0, '0, 1'b0, 1'b1, 1'b0);
    // R6 odd payload
    run_frame("R6", 11'h3C1, 1'b0, 4'd5, 64'h0000_00F0_0F3C_C381, 1'b0, '0, 1'b0, 1'b1, 1'b0);
    // R10 nobody acknowledges
    run_frame("R10", 11'h456, 1'b0, 4'd1, 64'h81, 1'b0, '0, 1'b0, 1'b0, 1'b0);
    // R8 lower identifier elsewhere wins
    run_frame("R8", 11'h123, 1'b0, 4'd3, 64'h00_7E_00, 1'b1, 11'h100, 1'b0, 1'b1, 1'b0);
    // R9 this node holds the lower identifier
    run_frame("R9", 11'h123, 1'b0, 4'd3, 64'h00_7E_00, 1'b1, 11'h200, 1'b0, 1'b1, 1'b0);
    // R9 data frame beats remote frame with same identifier
    run_frame("R9", 11'h055, 1'b0, 4'd2, 64'h0000_0000_0000_C33C, 1'b1, 11'h055, 1'b1, 1'b1, 1'b0);
    // R1 request pins toggled while busy
    run_frame("R1", 11'h6E2, 1'b0, 4'd4, 64'h0000_0000_A1B2_C3D4, 1'b0, '0, 1'b0, 1'b1, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule